// File: doc/BRIEF.md
# Transmit Descriptor Polling Engine

This block is the control core of a transmit DMA. It walks a list of transmit descriptors held in memory. A level-sensitive run control moves it out of the stopped state. It then fetches descriptors one at a time through a simple request/acknowledge read port. The read port returns the descriptor's ownership flag, an error flag, a ring-end flag, a chained flag and the next-descriptor pointer.

When a fetched descriptor belongs to the engine, the engine asks a downstream datapath to send the frame and waits for that datapath to finish. It then moves to the next descriptor. The next descriptor is found by one of three rules: the following slot of a contiguous ring, a wrap back to the list base, or the pointer carried in the descriptor. A descriptor still owned by software, or a failed fetch, suspends the engine. Suspension sets a sticky buffer-unavailable status bit and the normal summary bit. Software clears the status with a write-one-to-clear pulse. A poll-demand pulse makes the engine fetch the same descriptor again. Dropping the run control returns the engine to the stopped state, but only after any outstanding read has been acknowledged.

Top module: `txdesc_poll_engine`

## Requirements
- R1: After reset, eng_state is 0 (stopped), rd_req and xfer_req are low, and st_tbu and st_nis are low.
- R2: When run_en is high in the stopped state, the engine loads cur_addr from list_base and issues its first read at that address. eng_state is 1 while the engine is fetching or transmitting.
- R3: rd_req is held and rd_addr stays constant until rd_ack. In ring order, when a frame completes (xfer_done), the next address is cur_addr plus DESC_BYTES (16 by default).
- R4: When a descriptor has rd_ring_end high and rd_chained low, the address after its frame is list_base.
- R5: When a descriptor has rd_chained high, the address after its frame is its rd_next value, whatever rd_ring_end says.
- R6: A descriptor with rd_own=1 and rd_err=0 raises xfer_req. xfer_req stays high, with cur_addr unchanged, until xfer_done.
- R7: A fetch returning rd_own=0 or rd_err=1 moves the engine to eng_state 2 (suspended). No xfer_req is raised, st_tbu is set, and cur_addr keeps that descriptor's address.
- R8: st_tbu stays set until a clr_tbu pulse, and a set in the same cycle wins over the clear. st_nis is high exactly while st_tbu is high.
- R9: While suspended, no read is issued until a poll_demand pulse. The pulse makes the engine re-read the descriptor at the same address.
- R10: When run_en goes low during a fetch, rd_req is held until rd_ack. The engine then stops without transmitting or setting status. When run_en goes low while suspended, the engine stops on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run control level |
| poll_demand | input | 1 | One-cycle request to retry after suspension |
| list_base | input | AW | Base address of the descriptor list |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | AW | Descriptor read address |
| rd_ack | input | 1 | Read response valid |
| rd_own | input | 1 | Ownership bit (bit 31 of word 0); 1 means the engine owns the descriptor |
| rd_err | input | 1 | Error on this fetch |
| rd_ring_end | input | 1 | Descriptor is the last slot of the ring |
| rd_chained | input | 1 | Follow rd_next instead of ring order |
| rd_next | input | AW | Next-descriptor pointer word |
| xfer_req | output | 1 | Frame transmit request to the datapath |
| xfer_done | input | 1 | Datapath finished the frame |
| cur_addr | output | AW | Current descriptor address |
| eng_state | output | 2 | 0 stopped, 1 running, 2 suspended |
| st_tbu | output | 1 | Sticky transmit-buffer-unavailable status |
| st_nis | output | 1 | Normal interrupt summary |
| clr_tbu | input | 1 | Write-one-to-clear pulse for st_tbu |

## Verification
Assertions check, on every cycle, the properties that hold cycle by cycle:
- the read request is held with a steady address until it is acknowledged;
- the frame request is held with a steady current address;
- a start fetches from the base;
- an unowned fetch never raises a frame request;
- suspension always leaves status set;
- the status bit is sticky.

The whole address walk can only be shown by the bench's scenarios:
- ring wrap at varied ring lengths and ownership counts;
- chained orders with several strides, where the chain overrides ring end;
- error suspension followed by a poll-demand retry from the same slot;
- stopping during a slow fetch.

// File: rtl/txdp_pkg.sv
package txdp_pkg;

    typedef enum logic [1:0] {
        PS_STOP  = 2'd0,
        PS_FETCH = 2'd1,
        PS_XMIT  = 2'd2,
        PS_SUSP  = 2'd3
    } poll_state_e;

    typedef enum logic [1:0] {
        ADV_HOLD = 2'd0,
        ADV_BASE = 2'd1,
        ADV_SEQ  = 2'd2,
        ADV_LINK = 2'd3
    } adv_sel_e;

    typedef struct packed {
        logic own;
        logic err;
        logic ring_end;
        logic chained;
    } desc_flags_t;

    localparam logic [1:0] ENG_STOPPED = 2'd0;
    localparam logic [1:0] ENG_RUNNING = 2'd1;
    localparam logic [1:0] ENG_SUSPEND = 2'd2;

    function automatic logic [1:0] eng_code(input poll_state_e s);
        case (s)
            PS_STOP:  return ENG_STOPPED;
            PS_SUSP:  return ENG_SUSPEND;
            default:  return ENG_RUNNING;
        endcase
    endfunction

    function automatic adv_sel_e pick_step(input desc_flags_t f);
        if (f.chained)       return ADV_LINK;
        else if (f.ring_end) return ADV_BASE;
        else                 return ADV_SEQ;
    endfunction

    function automatic logic fetch_usable(input desc_flags_t f);
        return f.own && !f.err;
    endfunction

endpackage

// File: rtl/txdp_ctrl_fsm.sv
module txdp_ctrl_fsm
    import txdp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run_en,
    input  logic        poll_demand,
    input  logic        rd_ack,
    input  desc_flags_t flags,
    input  logic        xfer_done,
    output poll_state_e state,
    output logic        rd_req,
    output logic        xfer_req,
    output logic        start_load,
    output logic        capture,
    output logic        advance,
    output logic        susp_set
);

    poll_state_e state_q, state_d;

    always_comb begin
        state_d    = state_q;
        start_load = 1'b0;
        capture    = 1'b0;
        advance    = 1'b0;
        susp_set   = 1'b0;
        case (state_q)
            PS_STOP: begin
                if (run_en) begin
                    state_d    = PS_FETCH;
                    start_load = 1'b1;
                end
            end
            PS_FETCH: begin
                if (rd_ack) begin
                    if (!run_en) begin
                        state_d = PS_STOP;
                    end else if (!fetch_usable(flags)) begin
                        state_d  = PS_SUSP;
                        susp_set = 1'b1;
                    end else begin
                        state_d = PS_XMIT;
                        capture = 1'b1;
                    end
                end
            end
            PS_XMIT: begin
                if (xfer_done) begin
                    advance = 1'b1;
                    state_d = run_en ? PS_FETCH : PS_STOP;
                end
            end
            PS_SUSP: begin
                if (!run_en)          state_d = PS_STOP;
                else if (poll_demand) state_d = PS_FETCH;
            end
            default: state_d = PS_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_STOP;
        else     state_q <= state_d;
    end

    assign state    = state_q;
    assign rd_req   = (state_q == PS_FETCH);
    assign xfer_req = (state_q == PS_XMIT);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> rd_req) else $error("read request dropped early"); // R10

    AST_NO_XFER_UNOWNED: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ack && !flags.own) |=> !xfer_req) else $error("unowned descriptor sent"); // R7

endmodule

// File: rtl/txdp_addr_gen.sv
module txdp_addr_gen
    import txdp_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] list_base,
    input  logic          start_load,
    input  logic          capture,
    input  logic          advance,
    input  desc_flags_t   flags,
    input  logic [AW-1:0] next_ptr,
    output logic [AW-1:0] cur_addr
);

    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    logic [AW-1:0] cur_q;
    logic [AW-1:0] link_q;
    adv_sel_e      sel_q;
    logic [AW-1:0] stepped;

    always_comb begin
        case (sel_q)
            ADV_LINK: stepped = link_q;
            ADV_BASE: stepped = list_base;
            ADV_SEQ:  stepped = cur_q + STEP;
            default:  stepped = cur_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            link_q <= '0;
            sel_q  <= ADV_HOLD;
        end else begin
            if (capture) begin
                link_q <= next_ptr;
                sel_q  <= pick_step(flags);
            end
            if (start_load)   cur_q <= list_base;
            else if (advance) cur_q <= stepped;
        end
    end

    assign cur_addr = cur_q;

endmodule

// File: rtl/txdp_status.sv
module txdp_status (
    input  logic clk,
    input  logic rst,
    input  logic set_tbu,
    input  logic clr_tbu,
    output logic st_tbu,
    output logic st_nis
);

    logic tbu_q;

    always_ff @(posedge clk) begin
        if (rst)          tbu_q <= 1'b0;
        else if (set_tbu) tbu_q <= 1'b1;
        else if (clr_tbu) tbu_q <= 1'b0;
    end

    assign st_tbu = tbu_q;
    assign st_nis = |{tbu_q};

    AST_TBU_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st_tbu && !clr_tbu) |=> st_tbu) else $error("status lost without clear"); // R8

endmodule

// File: rtl/txdesc_poll_engine.sv
module txdesc_poll_engine
    import txdp_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_en,
    input  logic          poll_demand,
    input  logic [AW-1:0] list_base,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic          rd_own,
    input  logic          rd_err,
    input  logic          rd_ring_end,
    input  logic          rd_chained,
    input  logic [AW-1:0] rd_next,
    output logic          xfer_req,
    input  logic          xfer_done,
    output logic [AW-1:0] cur_addr,
    output logic [1:0]    eng_state,
    output logic          st_tbu,
    output logic          st_nis,
    input  logic          clr_tbu
);

    desc_flags_t flags;
    poll_state_e state;
    logic start_load, capture, advance, susp_set;

    assign flags = '{own: rd_own, err: rd_err, ring_end: rd_ring_end, chained: rd_chained};

    txdp_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .poll_demand(poll_demand),
        .rd_ack     (rd_ack),
        .flags      (flags),
        .xfer_done  (xfer_done),
        .state      (state),
        .rd_req     (rd_req),
        .xfer_req   (xfer_req),
        .start_load (start_load),
        .capture    (capture),
        .advance    (advance),
        .susp_set   (susp_set)
    );

    txdp_addr_gen #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .list_base (list_base),
        .start_load(start_load),
        .capture   (capture),
        .advance   (advance),
        .flags     (flags),
        .next_ptr  (rd_next),
        .cur_addr  (cur_addr)
    );

    txdp_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .set_tbu(susp_set),
        .clr_tbu(clr_tbu),
        .st_tbu (st_tbu),
        .st_nis (st_nis)
    );

    assign rd_addr   = cur_addr;
    assign eng_state = eng_code(state);

    AST_START_AT_BASE: assert property (@(posedge clk) disable iff (rst)
        ($rose(rd_req) && $past(eng_state) == ENG_STOPPED) |-> rd_addr == $past(list_base))
        else $error("first fetch not at base"); // R2

    AST_ADDR_STABLE_FETCH: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> $stable(rd_addr)) else $error("fetch address moved"); // R3

    AST_XFER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(cur_addr))) else $error("frame request dropped"); // R6

    AST_SUSP_SETS_TBU: assert property (@(posedge clk) disable iff (rst)
        (eng_state == ENG_SUSPEND && $past(eng_state) != ENG_SUSPEND) |-> st_tbu)
        else $error("suspended without status"); // R7

endmodule

// File: tb/sim_txdesc_poll_engine.sv
module sim_txdesc_poll_engine;

    localparam int AW = 32;
    localparam int DB = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          run_en = 0, poll_demand = 0, clr_tbu = 0;
    logic [AW-1:0] list_base = 32'h1000;
    logic          rd_req, xfer_req, st_tbu, st_nis;
    logic [AW-1:0] rd_addr, cur_addr;
    logic          rd_ack = 0, rd_own = 0, rd_err = 0, rd_ring_end = 0, rd_chained = 0;
    logic [AW-1:0] rd_next = '0;
    logic          xfer_done = 0;
    logic [1:0]    eng_state;

    txdesc_poll_engine #(.AW(AW), .DESC_BYTES(DB)) u0 (
        .clk(clk), .rst(rst), .run_en(run_en), .poll_demand(poll_demand),
        .list_base(list_base), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_own(rd_own), .rd_err(rd_err), .rd_ring_end(rd_ring_end),
        .rd_chained(rd_chained), .rd_next(rd_next), .xfer_req(xfer_req),
        .xfer_done(xfer_done), .cur_addr(cur_addr), .eng_state(eng_state),
        .st_tbu(st_tbu), .st_nis(st_nis), .clr_tbu(clr_tbu)
    );

    int runs = 0, fails = 0;
    bit m_own[8], m_err[8], m_re[8], m_ch[8];
    logic [AW-1:0] m_nxt[8];
    logic [AW-1:0] tx_log[64];
    logic [AW-1:0] fe_log[64];
    int tx_cnt = 0, fe_cnt = 0, resp_lat = 0;

    function automatic int idx_of(input logic [AW-1:0] a);
        logic [AW-1:0] d;
        d = (a - list_base) >> 4;
        return int'(d[2:0]);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_eng(input logic [1:0] code, output bit ok);
        ok = 0;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (eng_state == code) begin ok = 1; break; end
        end
    endtask

    // read responder
    initial begin
        forever begin
            @(negedge clk);
            if (rd_ack) rd_ack = 0;
            else if (rd_req) begin
                int i;
                repeat (resp_lat) @(negedge clk);
                i = idx_of(rd_addr);
                if (fe_cnt < 64) fe_log[fe_cnt] = rd_addr;
                fe_cnt++;
                rd_own = m_own[i]; rd_err = m_err[i];
                rd_ring_end = m_re[i]; rd_chained = m_ch[i]; rd_next = m_nxt[i];
                rd_ack = 1;
            end
        end
    end

    // datapath stub: sends the frame, then hands the descriptor back to software
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_done) xfer_done = 0;
            else if (xfer_req) begin
                logic [AW-1:0] a;
                a = cur_addr;
                if (tx_cnt < 64) tx_log[tx_cnt] = a;
                tx_cnt++;
                m_own[idx_of(a)] = 0;
                repeat (2) @(negedge clk);
                chk(xfer_req && cur_addr == a, "R6 request held", cur_addr, a);
                xfer_done = 1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    task automatic clear_mem();
        for (int i = 0; i < 8; i++) begin
            m_own[i] = 0; m_err[i] = 0; m_re[i] = 0; m_ch[i] = 0; m_nxt[i] = '0;
        end
        tx_cnt = 0; fe_cnt = 0;
    endtask

    task automatic go();
        @(negedge clk);
        run_en = 1;
    endtask

    task automatic halt();
        bit ok;
        @(negedge clk);
        run_en = 0;
        wait_eng(2'd0, ok);
        chk(ok, "R10 stop", {30'd0, eng_state}, 32'd0);
        repeat (3) @(negedge clk);
        clr_tbu = 1;
        @(negedge clk);
        clr_tbu = 0;
        chk(!st_tbu && !st_nis, "R8 clear", {31'd0, st_tbu}, 32'd0);
    endtask

    initial begin
        bit ok;
        bit seq_ok;
        logic [AW-1:0] e;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(eng_state == 2'd0, "R1 state", {30'd0, eng_state}, 32'd0);
        chk(!rd_req && !xfer_req, "R1 requests", {31'd0, rd_req | xfer_req}, 32'd0);
        chk(!st_tbu && !st_nis, "R1 status", {31'd0, st_tbu | st_nis}, 32'd0);

        // ring sweep: R2 R3 R4 R7 R8
        for (int n = 1; n <= 6; n++) begin
            for (int k = 0; k <= n; k++) begin
                clear_mem();
                list_base = 32'h1000 + 32'(n) * 32'h100;
                resp_lat = n % 3;
                for (int i = 0; i < k; i++) m_own[i] = 1;
                m_re[n-1] = 1;
                go();
                wait_eng(2'd2, ok);
                chk(ok, "R7 suspend reached", {30'd0, eng_state}, 32'd2);
                chk(fe_log[0] == list_base, "R2 first fetch", fe_log[0], list_base);
                chk(tx_cnt == k, "R3 frame count", tx_cnt, k);
                seq_ok = 1;
                for (int j = 0; j < k && j < 64; j++)
                    if (tx_log[j] != list_base + 32'(j * DB)) seq_ok = 0;
                chk(seq_ok, "R3 ring order", tx_log[0], list_base);
                e = (k == n) ? list_base : list_base + 32'(k * DB);
                chk(cur_addr == e, (k == n) ? "R4 wrap then suspend" : "R7 suspend addr", cur_addr, e);
                chk(st_tbu && st_nis, "R8 status set", {30'd0, st_tbu, st_nis}, 32'd3);
                halt();
            end
        end

        // chained sweep: R5 (ring_end on slot 2 must be overridden)
        for (int s = 1; s < 8; s += 2) begin
            clear_mem();
            list_base = 32'h4000;
            resp_lat = s % 2;
            for (int i = 0; i < 8; i++) begin
                m_own[i] = 1; m_ch[i] = 1;
                m_nxt[i] = list_base + 32'(((i + s) % 8) * DB);
            end
            m_re[2] = 1;
            go();
            wait_eng(2'd2, ok);
            chk(tx_cnt == 8, "R5 chain count", tx_cnt, 8);
            seq_ok = 1;
            for (int j = 0; j < 8; j++)
                if (tx_log[j] != list_base + 32'(((j * s) % 8) * DB)) seq_ok = 0;
            chk(seq_ok, "R5 chain order", tx_log[1], list_base + 32'((s % 8) * DB));
            chk(cur_addr == list_base, "R5 chain end", cur_addr, list_base);
            halt();
        end

        // error, idle suspend, poll demand: R7 R8 R9 R10
        for (int k = 0; k < 6; k++) begin
            int fc;
            clear_mem();
            list_base = 32'h8000;
            resp_lat = 0;
            for (int i = 0; i < 6; i++) m_own[i] = 1;
            m_re[5] = 1;
            m_err[k] = 1;
            go();
            wait_eng(2'd2, ok);
            e = list_base + 32'(k * DB);
            chk(tx_cnt == k, "R7 error frames", tx_cnt, k);
            chk(cur_addr == e && st_tbu, "R7 error suspend", cur_addr, e);
            fc = fe_cnt;
            repeat (10) @(negedge clk);
            chk(fe_cnt == fc && !rd_req, "R9 no fetch while suspended", fe_cnt, fc);
            clr_tbu = 1;
            @(negedge clk);
            clr_tbu = 0;
            chk(!st_tbu && !st_nis && eng_state == 2'd2, "R8 clear in suspend", {31'd0, st_tbu}, 32'd0);
            m_err[k] = 0;
            poll_demand = 1;
            @(negedge clk);
            poll_demand = 0;
            wait_eng(2'd2, ok);
            chk(fe_log[fc] == e, "R9 refetch same slot", fe_log[fc], e);
            chk(tx_cnt == 6, "R9 resumed frames", tx_cnt, 6);
            chk(cur_addr == list_base && st_tbu, "R4 wrap after resume", cur_addr, list_base);
            run_en = 0;
            @(negedge clk);
            chk(eng_state == 2'd0, "R10 stop from suspend", {30'd0, eng_state}, 32'd0);
            halt();
        end

        // stop during a slow fetch: R10
        clear_mem();
        list_base = 32'h1000;
        for (int i = 0; i < 8; i++) m_own[i] = 1;
        resp_lat = 4;
        go();
        for (int n = 0; n < 20 && !rd_req; n++) @(negedge clk);
        run_en = 0;
        @(negedge clk);
        chk(rd_req, "R10 request held", {31'd0, rd_req}, 32'd1);
        wait_eng(2'd0, ok);
        repeat (4) @(negedge clk);
        chk(ok && tx_cnt == 0 && !xfer_req, "R10 no frame after stop", tx_cnt, 0);
        chk(!st_tbu, "R10 no status after stop", {31'd0, st_tbu}, 32'd0);
        resp_lat = 0;

        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

endmodule